// File: doc/BRIEF.md
# Switching-Frequency Setpoint Register

This block holds the switching-frequency setpoint of a power stage as one 16-bit word in the signed linear-11 format. The top five bits are a two's-complement exponent and the low eleven bits are a two's-complement mantissa, so the value in kHz is the mantissa times two to the power of the exponent. Software reaches the word through a small request/response register channel at command code 0x33. Any other code is treated as a miss.

The block keeps two copies of the setpoint. The written (shadow) copy is what reads return. The applied copy is what the power stage uses. Every update of the applied copy decodes the linear-11 word to an integer kHz value and snaps it to one of twelve operating frequencies. While conversion is disabled, a write reaches the applied copy at once. While conversion is enabled, only the shadow changes. The applied copy then catches up on a restore pulse or an undervoltage pulse. Both pulses come from outside the block.

At reset the shadow is rebuilt from a non-volatile default frequency given in integer kHz. The exponent is the smallest one that lets the mantissa fit. The applied copy takes the snapped default. A warning output goes high whenever the applied frequency is above 1100 kHz.

Top module: `fsw_setpoint_reg`

## Requirements
- R1: A request is accepted on a rising edge where req_valid and req_ready are both high. A write with req_cmd 0x33 replaces the shadow word. A read with req_cmd 0x33 raises rsp_valid on the next edge, with rsp_rdata equal to the shadow word and rsp_err low.
- R2: The word is decoded with bits 15:11 as a signed exponent and bits 10:0 as a signed mantissa. The decoded value is mantissa × 2^exponent kHz.
- R3: The applied frequency is the decoded value snapped to a bin. The bins are: below 250 → 225, 250–299 → 275, 300–349 → 325, 350–409 → 375, 410–499 → 450, 500–599 → 550, 600–699 → 650, 700–819 → 750, 820–999 → 900, 1000–1199 → 1100, 1200–1399 → 1300, 1400 and above → 1500. A value exactly on a bin edge goes to the higher bin.
- R4: A negative decoded value gives 225. A positive exponent saturates the shift, so a very large result gives 1500. A negative exponent truncates the value toward zero before binning.
- R5: When conv_en is low, an accepted write at 0x33 also updates applied_khz, visible on the edge that accepts it.
- R6: When conv_en is high, an accepted write changes only the shadow word. applied_khz holds, and a read returns the newly written word.
- R7: A one-cycle restore_pulse or uvlo_pulse copies the snapped shadow value into applied_khz on that edge. If a write with conv_en low is accepted on the same edge, the written word is applied instead.
- R8: During reset (rst_n low) the shadow takes the encoding of nvm_fsw_khz with the smallest exponent ≥ 0 that fits the mantissa in 0..1023. For example, 1300 encodes as exponent 1, mantissa 650, which is 16'h0A8A. applied_khz takes the snapped default. rsp_valid is low.
- R9: hi_freq_warn is high exactly when applied_khz is above 1100.
- R10: A response is held with stable data while rsp_ready is low. req_ready is low while a response waits and rsp_ready is low.
- R11: A write to any other command code is ignored. A read of any other code answers rsp_rdata 0 with rsp_err high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_cmd | input | 8 | Command code |
| req_wdata | input | 16 | Write word, linear-11 |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 16 | Read word |
| rsp_err | output | 1 | Read hit an unknown command code |
| conv_en | input | 1 | Conversion enabled; blocks direct apply |
| restore_pulse | input | 1 | Restore event, one cycle |
| uvlo_pulse | input | 1 | Undervoltage event, one cycle |
| nvm_fsw_khz | input | 11 | Default frequency in kHz, taken during reset |
| applied_khz | output | 12 | Applied frequency in kHz |
| hi_freq_warn | output | 1 | Applied frequency above 1100 kHz |

## Verification
Each result is due one edge after its cause. The shadow word, applied_khz and hi_freq_warn change on the edge that accepts a write or that sees a restore or undervoltage pulse. A read response appears on the edge after the read is accepted. The bench drives inputs 1 ns after a rising edge and checks applied_khz and hi_freq_warn in the same window after the edge it expects to change them. A monitor pops queued read words at falling edges where the response handshake will complete on the next rising edge.

// File: rtl/fsw_pkg.sv
`timescale 1ns/1ps
package fsw_pkg;
  localparam int EXP_W    = 5;
  localparam int MAN_W    = 11;
  localparam int WORD_W   = EXP_W + MAN_W;
  localparam int KHZ_W    = 12;
  localparam int CMD_W    = 8;
  localparam int NUM_BINS = 12;

  localparam logic [CMD_W-1:0] CMD_FSW  = 8'h33;
  localparam logic [KHZ_W-1:0] KHZ_MAX  = '1;
  localparam logic [KHZ_W-1:0] WARN_KHZ = KHZ_W'(1100);

  // lowest decoded value that lands in each bin; bin 0 takes everything below
  localparam int BIN_FLOOR [NUM_BINS] =
    '{0, 250, 300, 350, 410, 500, 600, 700, 820, 1000, 1200, 1400};
  // operating frequency of each bin
  localparam int BIN_CENTER [NUM_BINS] =
    '{225, 275, 325, 375, 450, 550, 650, 750, 900, 1100, 1300, 1500};

  typedef struct packed {
    logic signed [EXP_W-1:0] exp;
    logic signed [MAN_W-1:0] man;
  } lin11_t;

  function automatic logic is_bin(logic [KHZ_W-1:0] khz);
    logic found;
    found = 1'b0;
    for (int i = 0; i < NUM_BINS; i++)
      if (khz == KHZ_W'(BIN_CENTER[i])) found = 1'b1;
    return found;
  endfunction
endpackage

// File: rtl/lin11_decode.sv
`timescale 1ns/1ps
module lin11_decode
  import fsw_pkg::*;
(
  input  lin11_t             word,
  output logic [KHZ_W-1:0]   khz
);
  localparam int SHW = 32;

  logic [SHW-1:0]   mag;
  logic [EXP_W-1:0] rsh;

  always_comb begin
    mag = '0;
    rsh = -word.exp;
    khz = '0;
    if (!word.man[MAN_W-1]) begin
      if (!word.exp[EXP_W-1])
        mag = {{(SHW-MAN_W){1'b0}}, word.man} << $unsigned(word.exp);
      else
        mag = {{(SHW-MAN_W){1'b0}}, word.man} >> rsh;
      khz = (mag > SHW'(KHZ_MAX)) ? KHZ_MAX : mag[KHZ_W-1:0];
    end
  end
endmodule

// File: rtl/freq_quantizer.sv
`timescale 1ns/1ps
module freq_quantizer
  import fsw_pkg::*;
(
  input  logic [KHZ_W-1:0] khz,
  output logic [KHZ_W-1:0] bin_khz
);
  logic [NUM_BINS-1:0] at_or_above;

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_edge
    if (g == 0) begin : g_base
      assign at_or_above[g] = 1'b0;
    end else begin : g_cmp
      assign at_or_above[g] = (khz >= KHZ_W'(BIN_FLOOR[g]));
    end
  end

  int cnt;
  always_comb begin
    cnt = 0;
    for (int i = 0; i < NUM_BINS; i++)
      if (at_or_above[i]) cnt = cnt + 1;
    bin_khz = KHZ_W'(BIN_CENTER[cnt]);
  end
endmodule

// File: rtl/lin11_encode.sv
`timescale 1ns/1ps
module lin11_encode
  import fsw_pkg::*;
#(
  parameter int IN_W = 11
) (
  input  logic [IN_W-1:0] khz,
  output lin11_t          word
);
  localparam logic [IN_W-1:0] MAN_MAX = IN_W'((1 << (MAN_W - 1)) - 1);

  logic found;
  always_comb begin
    word  = '0;
    found = 1'b0;
    for (int e = 0; e <= IN_W; e++) begin
      if (!found && ((khz >> e) <= MAN_MAX)) begin
        word.exp = EXP_W'(e);
        word.man = MAN_W'(khz >> e);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsw_setpoint_reg.sv
`timescale 1ns/1ps
module fsw_setpoint_reg
  import fsw_pkg::*;
#(
  parameter int NVM_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [CMD_W-1:0]    req_cmd,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  input  logic                conv_en,
  input  logic                restore_pulse,
  input  logic                uvlo_pulse,
  input  logic [NVM_W-1:0]    nvm_fsw_khz,
  output logic [KHZ_W-1:0]    applied_khz,
  output logic                hi_freq_warn
);
  lin11_t             shadow_q;
  logic [KHZ_W-1:0]   applied_q;
  logic               warn_q;
  logic               rsp_valid_q;
  logic [WORD_W-1:0]  rsp_rdata_q;
  logic               rsp_err_q;

  logic req_fire, cmd_hit, wr_hit, rd_fire, direct_apply, apply_now;
  lin11_t             src_word, dflt_word;
  logic [KHZ_W-1:0]   src_khz, src_bin, dflt_bin;

  assign req_ready    = !rsp_valid_q || rsp_ready;
  assign req_fire     = req_valid && req_ready;
  assign cmd_hit      = (req_cmd == CMD_FSW);
  assign wr_hit       = req_fire && req_write && cmd_hit;
  assign rd_fire      = req_fire && !req_write;
  assign direct_apply = wr_hit && !conv_en;
  assign apply_now    = direct_apply || restore_pulse || uvlo_pulse;
  assign src_word     = direct_apply ? lin11_t'(req_wdata) : shadow_q;

  lin11_decode u_dec (
    .word (src_word),
    .khz  (src_khz)
  );

  freq_quantizer u_q_src (
    .khz     (src_khz),
    .bin_khz (src_bin)
  );

  lin11_encode #(.IN_W(NVM_W)) u_enc (
    .khz  (nvm_fsw_khz),
    .word (dflt_word)
  );

  freq_quantizer u_q_dflt (
    .khz     (KHZ_W'(nvm_fsw_khz)),
    .bin_khz (dflt_bin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q    <= dflt_word;
      applied_q   <= dflt_bin;
      warn_q      <= (dflt_bin > WARN_KHZ);
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      if (wr_hit) shadow_q <= lin11_t'(req_wdata);
      if (apply_now) begin
        applied_q <= src_bin;
        warn_q    <= (src_bin > WARN_KHZ);
      end
      if (rd_fire) begin
        rsp_valid_q <= 1'b1;
        rsp_rdata_q <= cmd_hit ? WORD_W'(shadow_q) : '0;
        rsp_err_q   <= !cmd_hit;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rsp_rdata_q;
  assign rsp_err      = rsp_err_q;
  assign applied_khz  = applied_q;
  assign hi_freq_warn = warn_q;
endmodule

// File: rtl/fsw_setpoint_chk.sv
`timescale 1ns/1ps
module fsw_setpoint_chk
  import fsw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              conv_en,
  input logic              restore_pulse,
  input logic              uvlo_pulse,
  input logic [KHZ_W-1:0]  applied_khz,
  input logic              hi_freq_warn
);
  // R6
  applied_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && !restore_pulse && !uvlo_pulse) |=> $stable(applied_khz));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R3
  applied_in_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_bin(applied_khz));

  // R9
  warn_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_freq_warn == (applied_khz > WARN_KHZ));

  // R1
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));
endmodule

bind fsw_setpoint_reg fsw_setpoint_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .rsp_err       (rsp_err),
  .conv_en       (conv_en),
  .restore_pulse (restore_pulse),
  .uvlo_pulse    (uvlo_pulse),
  .applied_khz   (applied_khz),
  .hi_freq_warn  (hi_freq_warn)
);

// File: tb/tb_fsw_setpoint_reg.sv
`timescale 1ns/1ps
module tb_fsw_setpoint_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cmd = 8'h00;
  logic [15:0] req_wdata = 16'h0;
  logic        rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        conv_en = 1'b0, restore_pulse = 1'b0, uvlo_pulse = 1'b0;
  logic [10:0] nvm_fsw_khz = 11'd1300;
  logic [11:0] applied_khz;
  logic        hi_freq_warn;

  int n_chk = 0, n_fail = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fsw_setpoint_reg dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .conv_en(conv_en), .restore_pulse(restore_pulse),
    .uvlo_pulse(uvlo_pulse), .nvm_fsw_khz(nvm_fsw_khz),
    .applied_khz(applied_khz), .hi_freq_warn(hi_freq_warn)
  );

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] mk(int e, int m);
    return {5'(e), 11'(m)};
  endfunction

  function automatic logic [15:0] enc(int v);
    return (v < 1024) ? mk(0, v) : mk(1, v / 2);
  endfunction

  // expected applied frequency from the requirement text
  function automatic int model(logic [15:0] w);
    int e, m, v;
    e = int'($signed(w[15:11]));
    m = int'($signed(w[10:0]));
    if (e >= 0) v = m * (1 << e);
    else        v = m / (1 << (-e));
    if (v < 250)  return 225;
    if (v < 300)  return 275;
    if (v < 350)  return 325;
    if (v < 410)  return 375;
    if (v < 500)  return 450;
    if (v < 600)  return 550;
    if (v < 700)  return 650;
    if (v < 820)  return 750;
    if (v < 1000) return 900;
    if (v < 1200) return 1100;
    if (v < 1400) return 1300;
    return 1500;
  endfunction

  task automatic bus(logic wr, logic [7:0] cmd, logic [15:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_cmd = cmd; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] cmd, logic [15:0] d);
    bus(1'b1, cmd, d);
  endtask

  task automatic rd(logic [7:0] cmd, logic [15:0] expd, logic experr, string tag);
    exp_q.push_back({experr, expd});
    tag_q.push_back(tag);
    bus(1'b0, cmd, 16'h0);
  endtask

  task automatic pulse(bit which_uvlo);
    @(posedge clk); #1;
    if (which_uvlo) uvlo_pulse = 1'b1; else restore_pulse = 1'b1;
    @(posedge clk); #1;
    uvlo_pulse = 1'b0; restore_pulse = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected response", 1, 0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'({rsp_err, rsp_rdata}), int'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int vals[26] = '{0, 249, 250, 251, 299, 300, 349, 350, 409, 410, 499, 500,
                     599, 600, 699, 700, 819, 820, 999, 1000, 1198, 1200,
                     1398, 1400, 1648, 1650};
    logic [15:0] r4w[9];
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 reset state
    chk("R8 applied after reset", int'(applied_khz), 1300);
    chk("R9 warn after reset", int'(hi_freq_warn), 1);
    chk("R8 rsp_valid low", int'(rsp_valid), 0);
    rd(8'h33, 16'h0A8A, 1'b0, "R8 default shadow word");

    // R3 R5 bin edges with direct apply
    foreach (vals[i]) begin
      wr(8'h33, enc(vals[i]));
      chk($sformatf("R3 R5 bin for %0d", vals[i]), int'(applied_khz), model(enc(vals[i])));
      chk("R9 warn level", int'(hi_freq_warn), int'(model(enc(vals[i])) > 1100));
    end
    rd(8'h33, enc(1650), 1'b0, "R1 readback");

    // R2 R4 exponent, sign and truncation cases
    r4w = '{mk(15, 1000), mk(0, -5), mk(3, -1023), mk(-2, 1023), mk(-1, 501),
            mk(-1, 499), mk(-16, 1023), mk(1, 1023), mk(4, 30)};
    foreach (r4w[i]) begin
      wr(8'h33, r4w[i]);
      chk($sformatf("R4 R2 word %h", r4w[i]), int'(applied_khz), model(r4w[i]));
    end

    // R6 blocked update while enabled
    wr(8'h33, enc(450));
    chk("R5 set 450", int'(applied_khz), 450);
    conv_en = 1'b1;
    wr(8'h33, enc(800));
    chk("R6 applied held", int'(applied_khz), 450);
    rd(8'h33, enc(800), 1'b0, "R6 read returns written word");
    repeat (4) @(posedge clk);
    #1 chk("R6 applied still held", int'(applied_khz), 450);

    // R7 restore and undervoltage
    pulse(1'b0);
    chk("R7 restore applies shadow", int'(applied_khz), 750);
    wr(8'h33, enc(1000));
    chk("R6 held at 750", int'(applied_khz), 750);
    pulse(1'b1);
    chk("R7 uvlo applies shadow", int'(applied_khz), 1100);
    chk("R9 warn at 1100", int'(hi_freq_warn), 0);
    wr(8'h33, enc(1500));
    pulse(1'b0);
    chk("R7 restore to 1500", int'(applied_khz), 1500);
    chk("R9 warn above 1100", int'(hi_freq_warn), 1);

    // R11 other command code
    conv_en = 1'b0;
    wr(8'h34, enc(300));
    chk("R11 foreign write ignored", int'(applied_khz), 1500);
    rd(8'h33, enc(1500), 1'b0, "R11 shadow untouched");
    rd(8'h34, 16'h0000, 1'b1, "R11 foreign read error");

    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(8'h33, enc(1500), 1'b0, "R10 held response data");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 rsp_valid held", int'(rsp_valid), 1);
    chk("R10 req_ready low", int'(req_ready), 0);
    chk("R10 rdata held", int'(rsp_rdata), int'(enc(1500)));
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 all responses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule